// File: doc/BRIEF.md
# Fuse Bank Programming Sequencer

This block runs the whole burn of a configuration image into a set of fuse banks without step-by-step software control. One start pulse clears every bank control byte. The banks are then taken one after another, lowest index first. Each bank's control byte is walked through a fixed pattern: access enables on, burn enable added, burn enable removed, all off. The burn phase lasts a number of clock ticks given at start, so one sequencer serves silicon revisions that need different burn times.

After the last bank, the sequencer asks for the programming supply to be switched off. It waits a fixed settling time and then asks for a configuration reload. At that point it locks itself for good. A part that is already known to be burned can be flagged on an input, and then the sequence is refused from the start. Each refused start is reported on an error output.

Top module: `fuse_burn_seq`

## Requirements
- R1: After reset, busy, done, reload_req, supply_off and err are low, active_bank is 0, and every byte of bank_ctrl is 0x00.
- R2: A start pulse seen in the idle state, with prior_burn low, raises busy on the next cycle. All bank bytes then stay 0x00 and active_bank stays 0 for SETTLE_TICKS cycles (the clear phase).
- R3: Banks are processed in ascending order. Byte b of bank_ctrl (bits 8b+7 down to 8b) is the control byte of bank index b+1. While a bank is being handled, active_bank holds its index from 1 to NUM_BANKS, and at most one byte of bank_ctrl is nonzero.
- R4: Bit 0 of a control byte enables read/write and bit 1 enables bypass; bit 3 enables the burn. For each bank the byte is 0x03 for SETTLE_TICKS cycles, then 0x0B, then 0x03 for SETTLE_TICKS cycles, then 0x00 for SETTLE_TICKS cycles.
- R5: The 0x0B phase lasts burn_ticks cycles, using the value sampled with the accepted start pulse. A value of 0 counts as 1. Later changes to burn_ticks have no effect on a running sequence.
- R6: After the last bank, supply_off rises and stays high from then on. The reload request follows SUPPLY_WAIT_TICKS cycles later.
- R7: reload_req and done are high together for exactly one cycle. busy is high in that cycle and low in the next.
- R8: Once a sequence has completed, any further start pulse is refused: busy stays low, and err is high for one cycle on the cycle after the pulse.
- R9: A start pulse in the idle state while prior_burn is high is refused in the same way as in R8.
- R10: A start pulse while busy is high is ignored: the sequence carries on unchanged and err stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run the burn sequence |
| burn_ticks | input | CNT_W | Burn-enable duration in clock ticks, sampled at start |
| prior_burn | input | 1 | Part already burned; blocks any start |
| bank_ctrl | output | NUM_BANKS*8 | Control byte per bank, byte b for bank index b+1 |
| active_bank | output | IDX_W | Index of the bank being handled, 0 when none |
| supply_off | output | 1 | Request to switch the programming supply off |
| reload_req | output | 1 | One-cycle request to reload configuration |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse after a refused start |

## Verification
Some properties are checked on every cycle by the assertions:
- no more than one bank byte is nonzero;
- a burn phase is entered only from the armed step, and its count stays under the captured length;
- supply_off, once high, never falls, and it precedes the reload;
- done coincides with busy and is followed by idle;
- the locked state is permanent, and a flagged part never goes busy.

Other behaviour can only be shown by the bench scenarios, which compare every output on every cycle with a timeline built from the requirements:
- the exact length of each phase;
- the ascending bank order;
- the zero-tick burn case;
- burn_ticks being ignored in mid-run;
- starts being ignored while busy;
- error pulses for refused starts.

// File: rtl/fuse_burn_seq.sv
module fuse_burn_seq #(
  parameter int NUM_BANKS         = 10,
  parameter int CNT_W             = 32,
  parameter int SETTLE_TICKS      = 4,
  parameter int SUPPLY_WAIT_TICKS = 25000000,
  localparam int IDX_W            = $clog2(NUM_BANKS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [CNT_W-1:0]       burn_ticks,
  input  logic                   prior_burn,
  output logic [NUM_BANKS*8-1:0] bank_ctrl,
  output logic [IDX_W-1:0]       active_bank,
  output logic                   supply_off,
  output logic                   reload_req,
  output logic                   busy,
  output logic                   done,
  output logic                   err
);

  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_TICKS - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST   = CNT_W'(SUPPLY_WAIT_TICKS - 1);
  localparam logic [IDX_W-1:0] LAST_BANK   = IDX_W'(NUM_BANKS - 1);
  localparam logic [7:0]       BYTE_ARMED  = 8'h03;
  localparam logic [7:0]       BYTE_BURN   = 8'h0B;

  typedef enum logic [3:0] {
    S_IDLE, S_CLEAR, S_ARM, S_BURN, S_DISARM, S_RELEASE, S_SUPOFF, S_RELOAD, S_LOCKED
  } state_t;

  state_t           state;
  logic [IDX_W-1:0] bank;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] burn_len;
  logic             err_q;
  logic             cnt_zero;
  logic             in_bank;
  logic [7:0]       cur_byte;

  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      bank     <= '0;
      cnt      <= '0;
      burn_len <= CNT_W'(1);
      err_q    <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            if (prior_burn) begin
              err_q <= 1'b1;
            end else begin
              state    <= S_CLEAR;
              cnt      <= SETTLE_LAST;
              burn_len <= (burn_ticks == '0) ? CNT_W'(1) : burn_ticks;
            end
          end
        end
        S_CLEAR: begin
          if (cnt_zero) begin
            state <= S_ARM;
            bank  <= '0;
            cnt   <= SETTLE_LAST;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_ARM: begin
          if (cnt_zero) begin
            state <= S_BURN;
            cnt   <= burn_len - 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_BURN: begin
          if (cnt_zero) begin
            state <= S_DISARM;
            cnt   <= SETTLE_LAST;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_DISARM: begin
          if (cnt_zero) begin
            state <= S_RELEASE;
            cnt   <= SETTLE_LAST;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_RELEASE: begin
          if (cnt_zero) begin
            if (bank == LAST_BANK) begin
              state <= S_SUPOFF;
              cnt   <= WAIT_LAST;
            end else begin
              state <= S_ARM;
              bank  <= bank + 1'b1;
              cnt   <= SETTLE_LAST;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_SUPOFF: begin
          if (cnt_zero) state <= S_RELOAD;
          else cnt <= cnt - 1'b1;
        end
        S_RELOAD: state <= S_LOCKED;
        S_LOCKED: if (start) err_q <= 1'b1;
        default:  state <= S_IDLE;
      endcase
    end
  end

  assign in_bank     = (state == S_ARM) || (state == S_BURN) ||
                       (state == S_DISARM) || (state == S_RELEASE);
  assign cur_byte    = (state == S_BURN) ? BYTE_BURN :
                       ((state == S_ARM) || (state == S_DISARM)) ? BYTE_ARMED : 8'h00;
  assign active_bank = in_bank ? bank + 1'b1 : '0;
  assign busy        = (state != S_IDLE) && (state != S_LOCKED);
  assign reload_req  = (state == S_RELOAD);
  assign done        = (state == S_RELOAD);
  assign supply_off  = (state == S_SUPOFF) || (state == S_RELOAD) || (state == S_LOCKED);
  assign err         = err_q;

  logic [NUM_BANKS-1:0] byte_nz;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign bank_ctrl[8*g +: 8] = (in_bank && bank == IDX_W'(g)) ? cur_byte : 8'h00;
    assign byte_nz[g]          = |bank_ctrl[8*g +: 8];
  end

  // R3
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(byte_nz) <= 1);

  // R4
  burn_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BURN && $past(state) != S_BURN) |-> $past(state) == S_ARM);

  // R5
  burn_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BURN) |-> (cnt < burn_len));

  // R6
  supply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply_off |=> supply_off);

  // R6
  reload_after_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_req |-> $past(supply_off));

  // R7
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && reload_req));

  // R7
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOCKED) |=> (state == S_LOCKED && !busy));

  // R9
  prior_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && prior_burn) |=> !busy);

endmodule

// File: tb/fuse_burn_seq_tb.sv
module fuse_burn_seq_tb;
  localparam int NB     = 10;
  localparam int CW     = 32;
  localparam int SET    = 2;
  localparam int WAIT   = 8;
  localparam int IW     = $clog2(NB + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [CW-1:0]   burn_ticks = '0;
  logic            prior_burn = 1'b0;
  logic [NB*8-1:0] bank_ctrl;
  logic [IW-1:0]   active_bank;
  logic            supply_off, reload_req, busy, done, err;

  always #10 clk = ~clk;

  fuse_burn_seq #(
    .NUM_BANKS(NB), .CNT_W(CW), .SETTLE_TICKS(SET), .SUPPLY_WAIT_TICKS(WAIT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .burn_ticks(burn_ticks),
    .prior_burn(prior_burn), .bank_ctrl(bank_ctrl), .active_bank(active_bank),
    .supply_off(supply_off), .reload_req(reload_req), .busy(busy), .done(done), .err(err)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [NB*8-1:0] q_ctrl[$];
  int              q_act[$];
  logic [3:0]      q_flag[$];
  string           q_tag[$];
  bit              locked_m;
  bit              prev_idle;
  string           err_tag = "R9";
  logic            exp_busy;

  task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic push(logic [NB*8-1:0] c, int a, logic [3:0] f, string t);
    q_ctrl.push_back(c); q_act.push_back(a); q_flag.push_back(f); q_tag.push_back(t);
  endtask

  // flags: {supply_off, reload_req, busy, done}
  task automatic build(int b);
    int bl = (b == 0) ? 1 : b;
    for (int i = 0; i < SET; i++) push('0, 0, 4'b0010, "R2");
    for (int k = 0; k < NB; k++) begin
      logic [NB*8-1:0] arm_v, burn_v;
      arm_v  = (NB*8)'(8'h03) << (8 * k);
      burn_v = (NB*8)'(8'h0B) << (8 * k);
      for (int i = 0; i < SET; i++) push(arm_v, k + 1, 4'b0010, "R4");
      for (int i = 0; i < bl; i++)  push(burn_v, k + 1, 4'b0010, "R5");
      for (int i = 0; i < SET; i++) push(arm_v, k + 1, 4'b0010, "R4");
      for (int i = 0; i < SET; i++) push('0, k + 1, 4'b0010, "R4");
    end
    for (int i = 0; i < WAIT; i++) push('0, 0, 4'b1010, "R6");
    push('0, 0, 4'b1111, "R7");
  endtask

  task automatic step();
    logic [NB*8-1:0] ec;
    int ea;
    logic [3:0] ef;
    string t;
    logic ee;
    @(negedge clk);
    ee = 1'b0;
    if (prev_idle && start) begin
      if (prior_burn || locked_m) ee = 1'b1;
      else build(int'(burn_ticks));
    end
    if (q_ctrl.size() > 0) begin
      ec = q_ctrl.pop_front(); ea = q_act.pop_front();
      ef = q_flag.pop_front(); t = q_tag.pop_front();
      if (ef[2]) locked_m = 1'b1;
    end else begin
      ec = '0; ea = 0; ef = {locked_m, 3'b000}; t = locked_m ? "R8" : "R1";
    end
    exp_busy  = ef[1];
    prev_idle = !ef[1];
    chk(t, "bank_ctrl", 128'(bank_ctrl), 128'(ec));
    chk("R3", "active_bank", 128'(active_bank), 128'(ea));
    chk(t, "supply_off", 128'(supply_off), 128'(ef[3]));
    chk(t, "reload_req", 128'(reload_req), 128'(ef[2]));
    chk(t, "busy", 128'(busy), 128'(ef[1]));
    chk(t, "done", 128'(done), 128'(ef[0]));
    chk(ee ? err_tag : "R10", "err", 128'(err), 128'(ee));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    q_ctrl.delete(); q_act.delete(); q_flag.delete(); q_tag.delete();
    locked_m = 1'b0; prev_idle = 1'b1;
    // R1: reset state visible before the first running edge
    chk("R1", "busy", 128'(busy), 0);
    chk("R1", "bank_ctrl", 128'(bank_ctrl), 0);
    chk("R1", "supply_off", 128'(supply_off), 0);
    chk("R1", "err", 128'(err), 0);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic run_out();
    int guard = 0;
    while (exp_busy && guard < 5000) begin
      step();
      guard++;
    end
    step();
  endtask

  initial begin
    do_reset();
    repeat (3) step();
    // R9: already-burned part refuses start
    prior_burn = 1'b1; err_tag = "R9";
    pulse_start();
    repeat (3) step();
    prior_burn = 1'b0;
    // main run, burn 5 ticks
    burn_ticks = 5;
    pulse_start();
    repeat (20) step();
    // R10: start while busy ignored; R5: burn_ticks change ignored
    burn_ticks = 9;
    pulse_start();
    run_out();
    repeat (3) step();
    // R8: locked after completion
    err_tag = "R8";
    pulse_start();
    repeat (4) step();
    // R5: zero burn ticks counts as one
    do_reset();
    burn_ticks = 0; err_tag = "R9";
    pulse_start();
    step();
    run_out();
    // R5: another burn length, changed mid-run
    do_reset();
    burn_ticks = 3;
    pulse_start();
    burn_ticks = 1;
    run_out();
    repeat (2) step();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule